// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is a boundary-scan test access port for a chip whose test logic is reached through four serial pins and one asynchronous reset. It contains the standard sixteen-state controller and a two-bit instruction register. It also has three data registers selected by the instruction: a single-stage bypass, a 32-bit identification register and a boundary register. The boundary register covers a configurable number of input pins and output pins.

Input pins, clock pins included, get cells that only observe. Output pins get cells that observe the value the core drives. Each output cell also has a latched stage that can take over the pin when the external-test instruction is active. The pins themselves pass straight to and from the core. The only change to the pin path is the mux on the output side.

The instruction codes are fixed: 00 external test, 01 sample/preload, 10 identification, 11 bypass. The test clock `tck` is the block clock. `tms` and `tdi` are sampled on its rising edge, and `tdo` is launched on its falling edge.

Top module: `scan_tap`

## Requirements
- R1: While `trst` is high, regardless of `tck`, the controller is in Test-Logic-Reset, the instruction is identification (10), `tdo_oe` is 0, `tdo` is 1, and all latched output stages are 0, so `pin_out` equals `core_out`.
- R2: Five rising `tck` edges with `tms` = 1 bring the controller from any state to Test-Logic-Reset, and the instruction returns to identification (10).
- R3: Capture-IR loads binary 01 into the two-bit instruction shifter, which shifts out least significant bit first. A newly shifted instruction takes effect only in Update-IR.
- R4: Under identification (10) the selected register is 32 bits long and captures the `ID_VALUE` parameter with bit 0 forced to 1, shifted out least significant bit first.
- R5: Under bypass (11) the selected register is one stage that captures 0, so `tdo` repeats `tdi` one shift later.
- R6: Under external test (00) and sample/preload (01) the selected register is `NUM_IN`+`NUM_OUT` bits long. Bits [NUM_IN-1:0] capture `pin_in`, and the bits above capture `core_out`. Bit 0 is nearest `tdo`.
- R7: Under sample/preload, shifting and updating the boundary register leave `pin_out` equal to `core_out`, and they load the latched output stages.
- R8: Under external test, `pin_out` carries the latched output stages, which Update-DR loads from the top `NUM_OUT` bits of the boundary register.
- R9: The latched output stages change only in Update-DR, so `pin_out` holds its old latched value while new data is being shifted.
- R10: `tdo` changes only on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR, and at other times `tdo` rests at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst | input | 1 | Asynchronous test reset, active high |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pin_in | input | NUM_IN | Input pin values observed by the boundary cells |
| core_out | input | NUM_OUT | Values the core drives toward the output pins |
| pin_out | output | NUM_OUT | Values presented to the output pins |

## Verification
A table of scans runs each of the four instructions against different pin and core patterns. The captured streams then tell apart the boundary ordering (pins below core values), the forced identification bit, and the one-bit delay of the bypass. The external-test entries follow a preload with a different pattern, so the pin values separate the old latched data from the newly shifted data and from the core value. Directed runs cover the reset value of the instruction, escape through five TMS ones from inside Shift-DR, the falling-edge launch of `tdo`, and an asynchronous reset in the middle of external test.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    localparam int IR_W = 2;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        INS_EXTEST = 2'b00,
        INS_SAMPLE = 2'b01,
        INS_IDCODE = 2'b10,
        INS_BYPASS = 2'b11
    } tap_instr_e;

    localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } scan_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
        case (s)
            ST_TLR:    return tms ? ST_TLR    : ST_RTI;
            ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  return tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  return tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: return tms ? ST_SEL_DR : ST_RTI;
            default:   return ST_TLR;
        endcase
    endfunction

    function automatic logic is_boundary(input tap_instr_e i);
        return (i == INS_EXTEST) || (i == INS_SAMPLE);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output scan_ctl_t  ir_ctl,
    output scan_ctl_t  dr_ctl
);

    always_ff @(posedge tck or posedge trst) begin
        if (trst) state <= ST_TLR;
        else      state <= tap_next(state, tms);
    end

    always_comb begin
        in_reset       = (state == ST_TLR);
        ir_ctl.capture = (state == ST_CAP_IR);
        ir_ctl.shift   = (state == ST_SH_IR);
        ir_ctl.update  = (state == ST_UPD_IR);
        dr_ctl.capture = (state == ST_CAP_DR);
        dr_ctl.shift   = (state == ST_SH_DR);
        dr_ctl.update  = (state == ST_UPD_DR);
    end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       in_reset,
    input  scan_ctl_t  ctl,
    input  logic       tdi,
    output tap_instr_e instr,
    output logic       ir_lsb
);

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            ir_sh <= IR_CAPTURE;
            instr <= INS_IDCODE;
        end else begin
            if (ctl.capture)    ir_sh <= IR_CAPTURE;
            else if (ctl.shift) ir_sh <= {tdi, ir_sh[IR_W-1:1]};

            if (in_reset)        instr <= INS_IDCODE;
            else if (ctl.update) instr <= tap_instr_e'(ir_sh);
        end
    end

    assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import tap_pkg::*;
#(
    parameter int          NUM_IN   = 4,
    parameter int          NUM_OUT  = 4,
    parameter logic [31:0] ID_VALUE = 32'h5A3C_9E16
) (
    input  logic               tck,
    input  logic               trst,
    input  tap_instr_e         instr,
    input  scan_ctl_t          ctl,
    input  logic               tdi,
    input  logic [NUM_IN-1:0]  pin_in,
    input  logic [NUM_OUT-1:0] core_out,
    output logic               dr_lsb,
    output logic [NUM_OUT-1:0] latch_q
);

    localparam int BSR_LEN = NUM_IN + NUM_OUT;
    localparam logic [ID_W-1:0] ID_CAPTURE = ID_VALUE | 32'd1;

    logic [BSR_LEN-1:0] bsr_q;
    logic [ID_W-1:0]    id_q;
    logic               byp_q;
    logic               sel_bsr;

    assign sel_bsr = is_boundary(instr);

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            bsr_q <= '0;
        end else if (sel_bsr) begin
            if (ctl.capture)    bsr_q <= {core_out, pin_in};
            else if (ctl.shift) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
        end
    end

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            latch_q <= '0;
        end else if (sel_bsr && ctl.update) begin
            latch_q <= bsr_q[BSR_LEN-1:NUM_IN];
        end
    end

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            id_q <= '0;
        end else if (instr == INS_IDCODE) begin
            if (ctl.capture)    id_q <= ID_CAPTURE;
            else if (ctl.shift) id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or posedge trst) begin
        if (trst) begin
            byp_q <= 1'b0;
        end else if (instr == INS_BYPASS) begin
            if (ctl.capture)    byp_q <= 1'b0;
            else if (ctl.shift) byp_q <= tdi;
        end
    end

    always_comb begin
        case (instr)
            INS_IDCODE: dr_lsb = id_q[0];
            INS_BYPASS: dr_lsb = byp_q;
            default:    dr_lsb = bsr_q[0];
        endcase
    end

    // R9
    latch_only_in_update_chk: assert property (@(posedge tck) disable iff (trst)
        (latch_q != $past(latch_q)) |-> $past(ctl.update));

    // R5
    bypass_capture_zero_chk: assert property (@(posedge tck) disable iff (trst)
        (ctl.capture && instr == INS_BYPASS) |=> (byp_q == 1'b0));

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
    import tap_pkg::*;
#(
    parameter int          NUM_IN   = 4,
    parameter int          NUM_OUT  = 4,
    parameter logic [31:0] ID_VALUE = 32'h5A3C_9E16
) (
    input  logic               tck,
    input  logic               trst,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [NUM_IN-1:0]  pin_in,
    input  logic [NUM_OUT-1:0] core_out,
    output logic [NUM_OUT-1:0] pin_out
);

    tap_state_e         state;
    logic               in_reset;
    scan_ctl_t          ir_ctl;
    scan_ctl_t          dr_ctl;
    tap_instr_e         instr;
    logic               ir_lsb;
    logic               dr_lsb;
    logic [NUM_OUT-1:0] latch_q;

    tap_fsm u_fsm (
        .tck      (tck),
        .trst     (trst),
        .tms      (tms),
        .state    (state),
        .in_reset (in_reset),
        .ir_ctl   (ir_ctl),
        .dr_ctl   (dr_ctl)
    );

    tap_ir u_ir (
        .tck      (tck),
        .trst     (trst),
        .in_reset (in_reset),
        .ctl      (ir_ctl),
        .tdi      (tdi),
        .instr    (instr),
        .ir_lsb   (ir_lsb)
    );

    tap_dr #(
        .NUM_IN   (NUM_IN),
        .NUM_OUT  (NUM_OUT),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck      (tck),
        .trst     (trst),
        .instr    (instr),
        .ctl      (dr_ctl),
        .tdi      (tdi),
        .pin_in   (pin_in),
        .core_out (core_out),
        .dr_lsb   (dr_lsb),
        .latch_q  (latch_q)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out_cell
        assign pin_out[g] = (instr == INS_EXTEST) ? latch_q[g] : core_out[g];
    end

    always_ff @(negedge tck or posedge trst) begin
        if (trst) begin
            tdo    <= 1'b1;
            tdo_oe <= 1'b0;
        end else if (state == ST_SH_IR) begin
            tdo    <= ir_lsb;
            tdo_oe <= 1'b1;
        end else if (state == ST_SH_DR) begin
            tdo    <= dr_lsb;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b1;
            tdo_oe <= 1'b0;
        end
    end

    // R3
    ir_only_in_update_chk: assert property (@(posedge tck) disable iff (trst)
        (instr != $past(instr)) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR));

    // R2
    reset_state_idcode_chk: assert property (@(posedge tck) disable iff (trst)
        (state == ST_TLR) |=> (instr == INS_IDCODE));

    // R10
    tdo_oe_in_shift_chk: assert property (@(posedge tck) disable iff (trst)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R10
    tdo_idle_chk: assert property (@(posedge tck) disable iff (trst)
        !tdo_oe |-> tdo);

endmodule

// File: tb/scan_tap_tb.sv
`timescale 1ns/1ps
module scan_tap_tb;

    localparam int NI  = 4;
    localparam int NO  = 4;
    localparam int BL  = NI + NO;
    localparam logic [31:0] IDV = 32'h5A3C_9E16;
    localparam logic [31:0] ID_EXP = 32'h5A3C_9E17;
    localparam int NV = 6;

    // {instr[17:16], pin_in[15:12], core_out[11:8], shift data[7:0]}
    localparam logic [17:0] VEC [NV] = '{
        {2'b01, 4'hA, 4'h5, 8'h3C},
        {2'b00, 4'h3, 4'hC, 8'h96},
        {2'b11, 4'hF, 4'h0, 8'hB5},
        {2'b10, 4'h1, 4'h2, 8'h00},
        {2'b00, 4'h6, 4'h9, 8'h4E},
        {2'b01, 4'hC, 4'h3, 8'hF0}
    };

    logic          tck = 1'b0;
    logic          trst = 1'b1;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic          tdo;
    logic          tdo_oe;
    logic [NI-1:0] pin_in = '0;
    logic [NO-1:0] core_out = '0;
    logic [NO-1:0] pin_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  oe_bad;
    bit  edge_bad;

    always #2.5 tck = ~tck;

    scan_tap #(.NUM_IN(NI), .NUM_OUT(NO), .ID_VALUE(IDV)) u_dut (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .pin_in(pin_in), .core_out(core_out), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one TCK cycle: sample tdo after the falling edge, drive inputs, then
    // confirm tdo did not move at the rising edge
    task automatic step(input logic t_ms, input logic t_di, output logic o);
        logic oe;
        @(negedge tck); #1;
        o  = tdo;
        oe = tdo_oe;
        tms = t_ms;
        tdi = t_di;
        @(posedge tck); #1;
        if (tdo !== o) edge_bad = 1'b1;
        if (oe !== 1'b1) oe_bad = 1'b1;
    endtask

    task automatic walk(input logic t_ms);
        logic unused;
        @(negedge tck); #1;
        tms = t_ms;
        unused = 1'b0;
        @(posedge tck); #1;
    endtask

    // from Run-Test/Idle, scan n bits, end back in Run-Test/Idle
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din,
                        output logic [63:0] dout, output logic [NO-1:0] mid);
        logic b;
        dout = '0;
        oe_bad = 1'b0;
        walk(1'b1);
        if (is_ir) walk(1'b1);
        walk(1'b0);
        walk(1'b0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], b);
            dout[i] = b;
        end
        mid = pin_out;
        walk(1'b1);
        walk(1'b0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0]   dout;
        logic [63:0]   exp;
        logic [NO-1:0] mid;
        logic [NO-1:0] latch_m;
        logic [1:0]    ins;
        logic [7:0]    data;
        int            n;

        latch_m  = '0;
        edge_bad = 1'b0;
        core_out = 4'h6;
        pin_in   = 4'h9;
        #20;
        // R1: reset state
        chk("R1 tdo_oe", {63'd0, tdo_oe}, 64'd0);
        chk("R1 tdo idle", {63'd0, tdo}, 64'd1);
        chk("R1 pin_out", {60'd0, pin_out}, {60'd0, core_out});
        @(negedge tck); trst = 1'b0;
        walk(1'b0);
        // R10: idle output in Run-Test/Idle
        chk("R10 idle oe", {63'd0, tdo_oe}, 64'd0);
        chk("R10 idle tdo", {63'd0, tdo}, 64'd1);
        // R1 / R4: identification selected after reset
        scan(1'b0, 32, 64'd0, dout, mid);
        chk("R4 idcode after reset", dout, {32'd0, ID_EXP});

        for (int v = 0; v < NV; v++) begin
            ins      = VEC[v][17:16];
            pin_in   = VEC[v][15:12];
            core_out = VEC[v][11:8];
            data     = VEC[v][7:0];
            // R3: IR capture pattern
            scan(1'b1, 2, {62'd0, ins}, dout, mid);
            chk("R3 ir capture", dout, 64'd1);
            n = (ins == 2'b10) ? 32 : BL;
            scan(1'b0, n, {56'd0, data}, dout, mid);
            case (ins)
                2'b10: exp = {32'd0, ID_EXP};
                2'b11: exp = {56'd0, data[6:0], 1'b0};
                default: exp = {56'd0, core_out, pin_in};
            endcase
            case (ins)
                2'b10: chk("R4 idcode scan", dout, exp);
                2'b11: chk("R5 bypass scan", dout, exp);
                default: chk("R6 boundary capture", dout, exp);
            endcase
            // R9: latched stages hold during shift
            chk("R9 pin_out mid shift", {60'd0, mid},
                {60'd0, (ins == 2'b00) ? latch_m : core_out});
            if (ins == 2'b00 || ins == 2'b01) latch_m = data[7:4];
            #1;
            if (ins == 2'b00) chk("R8 extest drive", {60'd0, pin_out}, {60'd0, latch_m});
            else              chk("R7 pin_out follows core", {60'd0, pin_out}, {60'd0, core_out});
        end
        chk("R10 oe during shift", {63'd0, oe_bad}, 64'd0);
        chk("R10 tdo stable at rising edge", {63'd0, edge_bad}, 64'd0);

        // R2: five TMS ones from inside Shift-DR under bypass
        scan(1'b1, 2, 64'd3, dout, mid);
        walk(1'b1); walk(1'b0); walk(1'b0);
        for (int k = 0; k < 5; k++) walk(1'b1);
        walk(1'b0);
        scan(1'b0, 32, 64'd0, dout, mid);
        chk("R2 tms reset to idcode", dout, {32'd0, ID_EXP});

        // R8 then R1: external test with preloaded data, then async reset
        core_out = 4'h5;
        scan(1'b1, 2, 64'd1, dout, mid);
        scan(1'b0, BL, 64'hA0, dout, mid);
        scan(1'b1, 2, 64'd0, dout, mid);
        #1;
        chk("R8 preload then extest", {60'd0, pin_out}, 64'hA);
        @(negedge tck); #1.2;
        trst = 1'b1;
        #0.3;
        chk("R1 async reset pin_out", {60'd0, pin_out}, {60'd0, core_out});
        chk("R1 async reset oe", {63'd0, tdo_oe}, 64'd0);
        #3;
        trst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule